// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block judges a request to load one of six segment registers. Each request brings a 16-bit selector, the current privilege level and the attributes of the descriptor that selector names, already fetched. The attributes are: present, in-limit, code or data, a read/write bit, a conforming bit and the descriptor privilege level. In one cycle the block decides whether the load commits. If it does not commit, the block reports which fault class it raises and what error code goes with it. A committed load writes the selector and the descriptor base into a shadow register file. A read port on that file shows its contents.

The stack segment and the data segments use different check orderings. A null selector (bits 15:2 all zero) is accepted only by a data segment, and that register is marked null. A later reference through the block's reference port to a data register marked null reports a general-protection fault. A successful stack-segment load raises an interrupt-inhibit flag that lasts until the next instruction completes. A load that targets the code segment is always rejected.

Top module: `seg_load_guard`

## Requirements
- R1: After reset, done_valid, ref_gp and irq_inhibit are 0 and every shadow entry holds selector 0 and base 0. The four data entries (DS=0, ES=1, FS=2, GS=3) are marked null, so a reference to one of them reports ref_gp=1.
- R2: A request whose target code is 5 (CS), 6 or 7 completes with class 5 (illegal opcode) and error code 0, whatever the selector and the descriptor.
- R3: A stack-segment request (target 4) with a null selector completes with class 1 (general protection, code 0).
- R4: A non-null stack-segment request completes with class 2 (general protection with selector) in any of these cases: in-limit is 0; the RPL (selector bits 1:0) differs from CPL; the descriptor is code or not writable; or DPL differs from CPL. The error code is the selector with bits 1:0 cleared.
- R5: A stack-segment request that passes every R4 check but has present=0 completes with class 3 (stack fault with selector). When an R4 check also fails, class 2 wins.
- R6: A stack-segment request that passes every check completes with class 0 and writes its selector and base into shadow entry 4.
- R7: A null selector loaded into a data entry completes with class 0 and marks that entry null. A reference to that entry one cycle later raises ref_gp.
- R8: A non-null data-segment request completes with class 2 in any of these cases: in-limit is 0; the descriptor is code with the read bit 0; or the descriptor is data or non-conforming code and both RPL and CPL are numerically above DPL. A conforming readable code descriptor skips the privilege test.
- R9: A data-segment request that passes every R8 check but has present=0 completes with class 4 (not present with selector). When an R8 check also fails, class 2 wins.
- R10: Any request that completes with a non-zero class leaves every shadow entry unchanged.
- R11: A successful stack-segment load raises irq_inhibit from the next cycle. irq_inhibit falls once the following instruction completes, which is either an instr_done pulse or another load request. A second stack-segment load that completes while irq_inhibit is already high clears it and does not re-arm it.
- R12: A reference to a data entry that holds a non-null selector reports ref_gp=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present this cycle |
| req_target | input | 3 | Destination: 0 DS, 1 ES, 2 FS, 3 GS, 4 SS, 5 CS |
| req_sel | input | 16 | Selector to load; bits 1:0 are the RPL |
| req_cpl | input | 2 | Current privilege level |
| desc_present | input | 1 | Descriptor present bit |
| desc_code | input | 1 | 1 = code descriptor, 0 = data |
| desc_rw | input | 1 | Writable (data) or readable (code) |
| desc_conf | input | 1 | Conforming bit of a code descriptor |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_in_limit | input | 1 | Selector index lies inside the table |
| desc_base | input | BASE_W | Descriptor base stored on commit |
| instr_done | input | 1 | Some other instruction completed |
| ref_valid | input | 1 | Memory reference through a data entry |
| ref_target | input | 3 | Entry used by the reference |
| rd_target | input | 3 | Shadow entry shown on the read port |
| done_valid | output | 1 | Request result valid (one cycle after request) |
| done_class | output | 3 | 0 none, 1 GP0, 2 GP-sel, 3 SS-sel, 4 NP-sel, 5 UD |
| done_code | output | 16 | Error selector, or 0 |
| ref_gp | output | 1 | Reference hit a null data entry (one cycle after) |
| irq_inhibit | output | 1 | Interrupts held off for one instruction |
| rd_sel | output | 16 | Selector of the entry read |
| rd_base | output | BASE_W | Base of the entry read |

## Verification
The properties assume that instr_done and req_valid are never high in the same cycle, since each marks the completion of a different instruction. They also assume that a reference never names an entry being written in the same cycle. The directed tasks hold each request for one clock and return to idle between steps. They pulse instr_done only in idle cycles and issue references only after the load they depend on has finished.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    localparam int SEL_W   = 16;
    localparam int TGT_W   = 3;
    localparam int NUM_ENT = 6;

    typedef enum logic [TGT_W-1:0] {
        TGT_DS = 3'd0,
        TGT_ES = 3'd1,
        TGT_FS = 3'd2,
        TGT_GS = 3'd3,
        TGT_SS = 3'd4,
        TGT_CS = 3'd5
    } seg_tgt_e;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_GP0   = 3'd1,
        FC_GPSEL = 3'd2,
        FC_SSSEL = 3'd3,
        FC_NPSEL = 3'd4,
        FC_UD    = 3'd5
    } fault_cls_e;

    typedef struct packed {
        logic       present;
        logic       is_code;
        logic       rw;
        logic       conforming;
        logic [1:0] dpl;
        logic       in_limit;
    } desc_attr_t;

    function automatic logic sel_is_null(input logic [SEL_W-1:0] s);
        return s[SEL_W-1:2] == '0;
    endfunction

    function automatic logic [SEL_W-1:0] sel_err_code(input logic [SEL_W-1:0] s);
        return {s[SEL_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/seg_chk_stack.sv
module seg_chk_stack
    import seg_guard_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       cpl,
    input  desc_attr_t       attr,
    output fault_cls_e       cls
);
    logic prot_bad;

    always_comb begin
        prot_bad = !attr.in_limit || (sel[1:0] != cpl) || attr.is_code
                || !attr.rw || (attr.dpl != cpl);
        if (sel_is_null(sel))  cls = FC_GP0;
        else if (prot_bad)     cls = FC_GPSEL;
        else if (!attr.present) cls = FC_SSSEL;
        else                   cls = FC_NONE;
    end
endmodule

// File: rtl/seg_chk_data.sv
module seg_chk_data
    import seg_guard_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       cpl,
    input  desc_attr_t       attr,
    output fault_cls_e       cls
);
    logic type_bad;
    logic priv_bad;

    always_comb begin
        type_bad = attr.is_code && !attr.rw;
        priv_bad = (!attr.is_code || !attr.conforming)
                && (sel[1:0] > attr.dpl) && (cpl > attr.dpl);
        if (sel_is_null(sel))                            cls = FC_NONE;
        else if (!attr.in_limit || type_bad || priv_bad) cls = FC_GPSEL;
        else if (!attr.present)                          cls = FC_NPSEL;
        else                                             cls = FC_NONE;
    end
endmodule

// File: rtl/seg_shadow_file.sv
module seg_shadow_file
    import seg_guard_pkg::*;
#(
    parameter int BASE_W = 32,
    parameter int N_ENT  = NUM_ENT,
    parameter int N_DATA = 4,
    localparam int IDX_W = TGT_W,
    localparam int ENT_W = SEL_W + BASE_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [BASE_W-1:0]      wr_base,
    input  logic                   wr_null,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [SEL_W-1:0]       rd_sel,
    output logic [BASE_W-1:0]      rd_base,
    input  logic [IDX_W-1:0]       ref_idx,
    output logic                   ref_null,
    output logic [N_ENT*ENT_W-1:0] state_flat
);
    logic [SEL_W-1:0]  sel_q  [N_ENT];
    logic [BASE_W-1:0] base_q [N_ENT];
    logic [N_ENT-1:0]  null_q;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        localparam logic NULL_RST = (i < N_DATA);
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[i]  <= '0;
                base_q[i] <= '0;
                null_q[i] <= NULL_RST;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                sel_q[i]  <= wr_sel;
                base_q[i] <= wr_base;
                null_q[i] <= wr_null && NULL_RST;
            end
        end
        assign state_flat[i*ENT_W +: ENT_W] = {null_q[i], base_q[i], sel_q[i]};
    end

    always_comb begin
        rd_sel   = '0;
        rd_base  = '0;
        ref_null = 1'b0;
        for (int k = 0; k < N_ENT; k++) begin
            if (rd_idx == IDX_W'(k)) begin
                rd_sel  = sel_q[k];
                rd_base = base_q[k];
            end
            if (ref_idx == IDX_W'(k) && k < N_DATA) ref_null = null_q[k];
        end
    end
endmodule

// File: rtl/seg_irq_shadow.sv
module seg_irq_shadow (
    input  logic clk,
    input  logic rst,
    input  logic ss_commit,
    input  logic retire,
    output logic inhibit
);
    always_ff @(posedge clk) begin
        if (rst)                        inhibit <= 1'b0;
        else if (ss_commit && !inhibit) inhibit <= 1'b1;
        else if (inhibit && retire)     inhibit <= 1'b0;
    end
endmodule

// File: rtl/seg_load_guard.sv
module seg_load_guard
    import seg_guard_pkg::*;
#(
    parameter int BASE_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_target,
    input  logic [15:0]       req_sel,
    input  logic [1:0]        req_cpl,
    input  logic              desc_present,
    input  logic              desc_code,
    input  logic              desc_rw,
    input  logic              desc_conf,
    input  logic [1:0]        desc_dpl,
    input  logic              desc_in_limit,
    input  logic [BASE_W-1:0] desc_base,
    input  logic              instr_done,
    input  logic              ref_valid,
    input  logic [2:0]        ref_target,
    input  logic [2:0]        rd_target,
    output logic              done_valid,
    output logic [2:0]        done_class,
    output logic [15:0]       done_code,
    output logic              ref_gp,
    output logic              irq_inhibit,
    output logic [15:0]       rd_sel,
    output logic [BASE_W-1:0] rd_base
);
    localparam int ENT_W = SEL_W + BASE_W + 1;

    desc_attr_t attr;
    fault_cls_e stk_cls, dat_cls, cls;
    seg_tgt_e   tgt;
    logic       commit, ss_commit, ref_null;
    logic [NUM_ENT*ENT_W-1:0] shadow_flat;

    assign tgt  = seg_tgt_e'(req_target);
    assign attr = '{present: desc_present, is_code: desc_code, rw: desc_rw,
                    conforming: desc_conf, dpl: desc_dpl, in_limit: desc_in_limit};

    seg_chk_stack u_stk (.sel(req_sel), .cpl(req_cpl), .attr(attr), .cls(stk_cls));
    seg_chk_data  u_dat (.sel(req_sel), .cpl(req_cpl), .attr(attr), .cls(dat_cls));

    always_comb begin
        if (tgt == TGT_SS)       cls = stk_cls;
        else if (req_target < 4) cls = dat_cls;
        else                     cls = FC_UD;
    end

    assign commit    = req_valid && (cls == FC_NONE);
    assign ss_commit = commit && (tgt == TGT_SS);

    seg_shadow_file #(.BASE_W(BASE_W)) u_file (
        .clk(clk), .rst(rst),
        .wr_en(commit), .wr_idx(req_target), .wr_sel(req_sel),
        .wr_base(desc_base), .wr_null(sel_is_null(req_sel)),
        .rd_idx(rd_target), .rd_sel(rd_sel), .rd_base(rd_base),
        .ref_idx(ref_target), .ref_null(ref_null),
        .state_flat(shadow_flat)
    );

    seg_irq_shadow u_irq (
        .clk(clk), .rst(rst), .ss_commit(ss_commit),
        .retire(req_valid || instr_done), .inhibit(irq_inhibit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_valid <= 1'b0;
            done_class <= FC_NONE;
            done_code  <= '0;
            ref_gp     <= 1'b0;
        end else begin
            done_valid <= req_valid;
            ref_gp     <= ref_valid && ref_null;
            if (req_valid) begin
                done_class <= cls;
                done_code  <= (cls == FC_GPSEL || cls == FC_SSSEL || cls == FC_NPSEL)
                              ? sel_err_code(req_sel) : '0;
            end
        end
    end
endmodule

// File: rtl/seg_load_guard_chk.sv
module seg_load_guard_chk #(
    parameter int FLAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [2:0]        req_target,
    input logic [15:0]       req_sel,
    input logic              ref_valid,
    input logic              instr_done,
    input logic              done_valid,
    input logic [2:0]        done_class,
    input logic [15:0]       done_code,
    input logic              ref_gp,
    input logic              irq_inhibit,
    input logic [FLAT_W-1:0] shadow_flat
);
    // R2
    cs_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_target >= 3'd5) |=> (done_class == 3'd5 && done_code == 16'h0));

    // R3
    ss_null_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_target == 3'd4 && req_sel[15:2] == 14'h0) |=> (done_class == 3'd1));

    // R10
    fault_keeps_file_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_class != 3'd0) |-> $stable(shadow_flat));

    // R11
    inhibit_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_inhibit && (req_valid || instr_done)) |=> !irq_inhibit);

    // R11
    inhibit_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_inhibit) |-> $past(req_valid && req_target == 3'd4));

    // R7
    ref_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ref_gp |-> $past(ref_valid));

    // R1
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(req_valid));
endmodule

bind seg_load_guard seg_load_guard_chk #(.FLAT_W(seg_guard_pkg::NUM_ENT*(seg_guard_pkg::SEL_W+BASE_W+1))) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
    .req_sel(req_sel), .ref_valid(ref_valid), .instr_done(instr_done),
    .done_valid(done_valid), .done_class(done_class), .done_code(done_code),
    .ref_gp(ref_gp), .irq_inhibit(irq_inhibit), .shadow_flat(shadow_flat)
);

// File: tb/seg_load_guard_bench.sv
module seg_load_guard_bench;
    localparam int BW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0;
    logic [2:0] req_target = 0;
    logic [15:0] req_sel = 0;
    logic [1:0] req_cpl = 0;
    logic desc_present = 0, desc_code = 0, desc_rw = 0, desc_conf = 0, desc_in_limit = 0;
    logic [1:0] desc_dpl = 0;
    logic [BW-1:0] desc_base = 0;
    logic instr_done = 0, ref_valid = 0;
    logic [2:0] ref_target = 0, rd_target = 0;
    logic done_valid, ref_gp, irq_inhibit;
    logic [2:0] done_class;
    logic [15:0] done_code, rd_sel;
    logic [BW-1:0] rd_base;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    seg_load_guard #(.BASE_W(BW)) u_seg_load_guard (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
        .req_sel(req_sel), .req_cpl(req_cpl), .desc_present(desc_present),
        .desc_code(desc_code), .desc_rw(desc_rw), .desc_conf(desc_conf),
        .desc_dpl(desc_dpl), .desc_in_limit(desc_in_limit), .desc_base(desc_base),
        .instr_done(instr_done), .ref_valid(ref_valid), .ref_target(ref_target),
        .rd_target(rd_target), .done_valid(done_valid), .done_class(done_class),
        .done_code(done_code), .ref_gp(ref_gp), .irq_inhibit(irq_inhibit),
        .rd_sel(rd_sel), .rd_base(rd_base)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one load request held for one clock; results sampled at the following negedge
    task automatic load(input logic [2:0] t, input logic [15:0] s, input logic [1:0] c,
                        input logic p, input logic cd, input logic rw, input logic cf,
                        input logic [1:0] d, input logic lim, input logic [BW-1:0] b);
        @(negedge clk);
        req_valid = 1; req_target = t; req_sel = s; req_cpl = c;
        desc_present = p; desc_code = cd; desc_rw = rw; desc_conf = cf;
        desc_dpl = d; desc_in_limit = lim; desc_base = b;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic reference(input logic [2:0] t);
        @(negedge clk);
        ref_valid = 1; ref_target = t;
        @(negedge clk);
        ref_valid = 0;
    endtask

    task automatic peek(input logic [2:0] t);
        rd_target = t;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 done_valid", done_valid, 0);
        chk("R1 irq_inhibit", irq_inhibit, 0);
        chk("R1 ref_gp", ref_gp, 0);
        for (int i = 0; i < 6; i++) begin
            peek(3'(i));
            chk("R1 rd_sel", rd_sel, 0);
            chk("R1 rd_base", rd_base, 0);
        end
        reference(3'd2);
        chk("R1 data entry null", ref_gp, 1);
    endtask

    task automatic t_code_target();
        load(3'd5, 16'h0018, 2'd0, 1, 1, 1, 0, 2'd0, 1, 32'h1111);
        chk("R2 CS class", done_class, 5);
        chk("R2 CS code", done_code, 0);
        peek(3'd5);
        chk("R10 CS untouched", rd_sel, 0);
        load(3'd7, 16'h0020, 2'd0, 1, 0, 1, 0, 2'd0, 1, 32'h2222);
        chk("R2 target7 class", done_class, 5);
    endtask

    task automatic t_ss_null();
        load(3'd4, 16'h0002, 2'd2, 1, 0, 1, 0, 2'd2, 1, 32'h3);
        chk("R3 valid", done_valid, 1);
        chk("R3 class", done_class, 1);
        chk("R3 code", done_code, 0);
        peek(3'd4);
        chk("R10 SS untouched", rd_sel, 0);
    endtask

    task automatic t_ss_prot();
        load(3'd4, 16'h0010, 2'd0, 1, 0, 1, 0, 2'd0, 0, 32'h4);
        chk("R4 limit class", done_class, 2);
        chk("R4 limit code", done_code, 16'h0010);
        load(3'd4, 16'h0011, 2'd0, 1, 0, 1, 0, 2'd0, 1, 32'h4);
        chk("R4 rpl class", done_class, 2);
        chk("R4 rpl code", done_code, 16'h0010);
        load(3'd4, 16'h0010, 2'd0, 1, 1, 1, 0, 2'd0, 1, 32'h4);
        chk("R4 code seg", done_class, 2);
        load(3'd4, 16'h0010, 2'd0, 1, 0, 0, 0, 2'd0, 1, 32'h4);
        chk("R4 readonly", done_class, 2);
        load(3'd4, 16'h0010, 2'd0, 1, 0, 1, 0, 2'd1, 1, 32'h4);
        chk("R4 dpl", done_class, 2);
        peek(3'd4);
        chk("R10 SS after prot faults", rd_sel, 0);
    endtask

    task automatic t_ss_np();
        load(3'd4, 16'h0013, 2'd3, 0, 0, 1, 0, 2'd3, 1, 32'h5);
        chk("R5 class", done_class, 3);
        chk("R5 code", done_code, 16'h0010);
        load(3'd4, 16'h0013, 2'd3, 0, 0, 0, 0, 2'd3, 1, 32'h5);
        chk("R5 order", done_class, 2);
        chk("R11 no inhibit on fault", irq_inhibit, 0);
    endtask

    task automatic t_ss_ok();
        load(3'd4, 16'h002B, 2'd3, 1, 0, 1, 0, 2'd3, 1, 32'hCAFE0000);
        chk("R6 class", done_class, 0);
        peek(3'd4);
        chk("R6 sel", rd_sel, 16'h002B);
        chk("R6 base", rd_base, 32'hCAFE0000);
        chk("R11 raised", irq_inhibit, 1);
        @(negedge clk);
        chk("R11 held idle", irq_inhibit, 1);
        instr_done = 1;
        @(negedge clk);
        instr_done = 0;
        chk("R11 cleared", irq_inhibit, 0);
    endtask

    task automatic t_ss_chain();
        load(3'd4, 16'h0030, 2'd0, 1, 0, 1, 0, 2'd0, 1, 32'hA);
        chk("R11 first raises", irq_inhibit, 1);
        load(3'd4, 16'h0038, 2'd0, 1, 0, 1, 0, 2'd0, 1, 32'hB);
        chk("R11 second no rearm", irq_inhibit, 0);
        peek(3'd4);
        chk("R6 second commits", rd_sel, 16'h0038);
    endtask

    task automatic t_data_null();
        load(3'd0, 16'h0003, 2'd3, 0, 0, 0, 0, 2'd0, 0, 32'h77);
        chk("R7 class", done_class, 0);
        peek(3'd0);
        chk("R7 sel", rd_sel, 16'h0003);
        reference(3'd0);
        chk("R7 ref gp", ref_gp, 1);
        load(3'd0, 16'h0020, 2'd0, 1, 0, 1, 0, 2'd0, 1, 32'h88);
        chk("R12 load", done_class, 0);
        reference(3'd0);
        chk("R12 ref ok", ref_gp, 0);
    endtask

    task automatic t_data_prot();
        load(3'd1, 16'h0040, 2'd0, 1, 0, 1, 0, 2'd0, 0, 32'h1);
        chk("R8 limit", done_class, 2);
        chk("R8 code", done_code, 16'h0040);
        load(3'd1, 16'h0040, 2'd0, 1, 1, 0, 0, 2'd0, 1, 32'h1);
        chk("R8 exec-only", done_class, 2);
        load(3'd1, 16'h0043, 2'd3, 1, 0, 1, 0, 2'd0, 1, 32'h1);
        chk("R8 data priv", done_class, 2);
        peek(3'd1);
        chk("R10 ES untouched", rd_sel, 0);
        load(3'd1, 16'h0043, 2'd0, 1, 0, 1, 0, 2'd0, 1, 32'h2);
        chk("R8 rpl only above", done_class, 0);
        load(3'd2, 16'h004B, 2'd3, 1, 1, 1, 1, 2'd0, 1, 32'h3);
        chk("R8 conforming ok", done_class, 0);
        load(3'd3, 16'h004B, 2'd3, 1, 1, 1, 0, 2'd0, 1, 32'h3);
        chk("R8 nonconforming", done_class, 2);
    endtask

    task automatic t_data_np();
        load(3'd3, 16'h0050, 2'd0, 0, 0, 1, 0, 2'd0, 1, 32'h9);
        chk("R9 class", done_class, 4);
        chk("R9 code", done_code, 16'h0050);
        load(3'd3, 16'h0050, 2'd0, 0, 0, 1, 0, 2'd0, 0, 32'h9);
        chk("R9 order", done_class, 2);
        peek(3'd3);
        chk("R10 GS untouched", rd_sel, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_code_target();
        t_ss_null();
        t_ss_prot();
        t_ss_np();
        t_ss_ok();
        t_ss_chain();
        t_data_null();
        t_data_prot();
        t_data_np();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule